// File: doc/BRIEF.md
# Reset and Calibration Sequencer

This block gathers every reason a line transceiver may need resetting and turns them into two reset outputs: one for the digital logic and one for the analog front end. There are three classes of request. Chip-wide requests reset both domains and reload the configuration straps. They come from a filtered external reset pin, from missing power-good or oscillator-stable, and from a self-clearing bit in the control register. A digital-only request resets the digital side and leaves the analog side running. It comes from a bit in the configuration register. Analog-only requests reset the analog side and then recalibrate it. They come from either edge of the power-down pin and from any change of the speed selection.

Every sequence has two parts. First comes a reset phase of `RST_CYCLES` clocks. A calibration phase of `CAL_CYCLES` clocks follows whenever the analog side was reset. The calibration is modelled as a timer only. A busy flag in the control register reads 1 until the sequence ends. A request that arrives while a sequence is running restarts it from the reset phase. The new request is merged with the one already pending, so the outcome is never weaker than either of them. Register accesses work throughout calibration.

Top module: `rst_cal_seq`

## Requirements
- R1: While `rst_n` is low, and for as long as the synchronized power-good or oscillator-stable input is low, both `rst_dig` and `rst_ana` are 1.
- R2: `rst_pin` causes a chip-wide reset only after its synchronized value has been high for `FILT_CYCLES` consecutive clocks (25 clocks of 8 ns, i.e. 200 ns). A shorter high pulse has no effect on either reset output.
- R3: Writing a word with bit 15 set to address 0x00 starts a chip-wide reset. Both reset outputs are 1 in the cycle after the write.
- R4: A chip-wide sequence ends its reset phase by copying `strap_in` into the mode field (bits [MODE_W-1:0] of address 0x00). Calibration then runs for `CAL_CYCLES` clocks with both reset outputs at 0 and the busy bit at 1.
- R5: Bit 15 of address 0x00 reads 1 exactly while a reset or calibration phase is running, and 0 otherwise. Every other address reads 0.
- R6: Writing a word with bit 0 set to address 0x17 holds `rst_dig` at 1 for `RST_CYCLES` clocks, leaves `rst_ana` at 0, runs no calibration, and restores the mode field to the last latched strap value.
- R7: Each rising or falling edge of `pwrdn_pin` holds `rst_ana` at 1 for `RST_CYCLES` clocks and then runs calibration for `CAL_CYCLES` clocks. `rst_dig` stays at 0.
- R8: Each change of `speed_sel` starts the same analog-only sequence as R7.
- R9: A write to address 0x00 updates the mode field whenever `rst_dig` is 0, including during calibration. While `rst_dig` is 1, writes are ignored.
- R10: A request that arrives during a running sequence restarts the reset phase with the union of the pending and new reset domains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| rst_pin | input | 1 | External reset request, asynchronous, active high |
| pwr_good | input | 1 | Supply above threshold, asynchronous |
| osc_stable | input | 1 | Oscillator settled, asynchronous |
| pwrdn_pin | input | 1 | Power-down request, asynchronous |
| speed_sel | input | 1 | Line speed selection, synchronous to clk |
| strap_in | input | MODE_W | Configuration straps sampled at chip-wide reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| rst_dig | output | 1 | Digital domain reset, active high |
| rst_ana | output | 1 | Analog domain reset, active high |

## Verification
The checker watches every cycle for the following. A held power or oscillator fault, or a software chip reset, always lands in both resets in the next cycle. An isolated digital or analog request from idle touches only its own domain. Neither reset output is ever active without the busy flag. The pin filter never fires in a cycle where the synchronized pin is low. While `rst_dig` is held, the mode field shows the latched straps and not written data. Exact durations of the reset and calibration phases, the rejection of a pulse one clock short of the filter length, register writes landing during calibration, and the merging of a digital request into a running analog sequence are visible only in the bench's scenarios against its reference model.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam logic [4:0] ADDR_CTRL    = 5'h00;
  localparam logic [4:0] ADDR_CFG     = 5'h17;
  localparam int         CTRL_RST_BIT = 15;
  localparam int         CFG_DRST_BIT = 0;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RST  = 2'd1,
    PH_CAL  = 2'd2
  } phase_t;

  // Which parts a pending sequence must touch.
  typedef struct packed {
    logic strap;
    logic dig;
    logic ana;
  } need_t;
endpackage

// File: rtl/rcs_sync.sv
module rcs_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d[i];
        s2_q <= s1_q;
      end
    end
    assign q[i] = s2_q;
  end
endmodule

// File: rtl/rcs_pin_filter.sv
module rcs_pin_filter #(
  parameter int LEN = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic hit
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign hit = (cnt_q == CW'(LEN));

  always_comb begin
    if (!pin)     cnt_d = '0;
    else if (hit) cnt_d = cnt_q;
    else          cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rcs_seq.sv
module rcs_seq
  import rcs_pkg::*;
#(
  parameter int RST_CYCLES = 8,
  parameter int CAL_CYCLES = 5_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_req,
  input  logic dig_req,
  input  logic ana_req,
  output logic rst_dig,
  output logic rst_ana,
  output logic busy,
  output logic strap_ld
);
  localparam int MAXC = (CAL_CYCLES > RST_CYCLES) ? CAL_CYCLES : RST_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] RST_LOAD = CW'(RST_CYCLES - 1);
  localparam logic [CW-1:0] CAL_LOAD = CW'(CAL_CYCLES - 1);

  phase_t        ph_q, ph_d;
  need_t         need_q, need_d, req;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          any_req;

  assign req     = need_t'({chip_req, chip_req | dig_req, chip_req | ana_req});
  assign any_req = chip_req | dig_req | ana_req;

  always_comb begin
    ph_d     = ph_q;
    need_d   = need_q;
    cnt_d    = cnt_q;
    strap_ld = 1'b0;
    if (any_req) begin
      ph_d   = PH_RST;
      need_d = need_t'(((ph_q == PH_IDLE) ? need_t'('0) : need_q) | req);
      cnt_d  = RST_LOAD;
    end else begin
      case (ph_q)
        PH_RST: begin
          if (cnt_q == '0) begin
            strap_ld = need_q.strap;
            if (need_q.ana) begin
              ph_d  = PH_CAL;
              cnt_d = CAL_LOAD;
            end else begin
              ph_d = PH_IDLE;
            end
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        PH_CAL: begin
          if (cnt_q == '0) ph_d = PH_IDLE;
          else             cnt_d = cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_RST;
      need_q  <= need_t'('1);
      cnt_q   <= RST_LOAD;
      rst_dig <= 1'b1;
      rst_ana <= 1'b1;
      busy    <= 1'b1;
    end else begin
      ph_q    <= ph_d;
      need_q  <= need_d;
      cnt_q   <= cnt_d;
      rst_dig <= (ph_d == PH_RST) && need_d.dig;
      rst_ana <= (ph_d == PH_RST) && need_d.ana;
      busy    <= (ph_d != PH_IDLE);
    end
  end
endmodule

// File: rtl/rcs_regs.sv
module rcs_regs
  import rcs_pkg::*;
#(
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_dig,
  input  logic              busy,
  input  logic              strap_ld,
  input  logic [MODE_W-1:0] strap_in,
  input  logic              reg_we,
  input  logic [4:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              sw_chip,
  output logic              sw_dig,
  output logic [MODE_W-1:0] mode,
  output logic [MODE_W-1:0] strap_q
);
  logic [MODE_W-1:0] mode_d, strap_d;
  logic              wr_ctrl;
  logic              wdata_unused;

  assign wdata_unused = ^reg_wdata;
  assign wr_ctrl = reg_we && !rst_dig && (reg_addr == ADDR_CTRL);
  assign sw_chip = wr_ctrl && reg_wdata[CTRL_RST_BIT];
  assign sw_dig  = reg_we && !rst_dig && (reg_addr == ADDR_CFG) && reg_wdata[CFG_DRST_BIT];

  always_comb begin
    strap_d = strap_q;
    mode_d  = mode;
    if (strap_ld) begin
      strap_d = strap_in;
      mode_d  = strap_in;
    end else if (rst_dig) begin
      mode_d  = strap_q;
    end else if (wr_ctrl) begin
      mode_d  = reg_wdata[MODE_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_CTRL) begin
      reg_rdata[CTRL_RST_BIT] = busy;
      reg_rdata[MODE_W-1:0]   = mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q <= '0;
      mode    <= '0;
    end else begin
      strap_q <= strap_d;
      mode    <= mode_d;
    end
  end
endmodule

// File: rtl/rst_cal_seq.sv
module rst_cal_seq
  import rcs_pkg::*;
#(
  parameter int FILT_CYCLES = 25,
  parameter int RST_CYCLES  = 8,
  parameter int CAL_CYCLES  = 5_000_000,
  parameter int MODE_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_pin,
  input  logic              pwr_good,
  input  logic              osc_stable,
  input  logic              pwrdn_pin,
  input  logic              speed_sel,
  input  logic [MODE_W-1:0] strap_in,
  input  logic              reg_we,
  input  logic [4:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              rst_dig,
  output logic              rst_ana
);
  logic [3:0]        async_s;
  logic              pin_s, pd_s, pg_s, osc_s;
  logic              filt_hit;
  logic              pd_q, spd_q;
  logic              sw_chip, sw_dig;
  logic              chip_req, dig_req, ana_req;
  logic              busy, strap_ld;
  logic [MODE_W-1:0] mode, strap_q;

  rcs_sync #(.W(4)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d ({osc_stable, pwr_good, pwrdn_pin, rst_pin}),
    .q (async_s)
  );
  assign {osc_s, pg_s, pd_s, pin_s} = async_s;

  rcs_pin_filter #(.LEN(FILT_CYCLES)) u_filt (
    .clk (clk),
    .rst_n (rst_n),
    .pin (pin_s),
    .hit (filt_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q  <= 1'b0;
      spd_q <= 1'b0;
    end else begin
      pd_q  <= pd_s;
      spd_q <= speed_sel;
    end
  end

  assign chip_req = filt_hit | ~pg_s | ~osc_s | sw_chip;
  assign dig_req  = sw_dig;
  assign ana_req  = (pd_s ^ pd_q) | (speed_sel ^ spd_q);

  rcs_seq #(.RST_CYCLES(RST_CYCLES), .CAL_CYCLES(CAL_CYCLES)) u_seq (
    .clk (clk),
    .rst_n (rst_n),
    .chip_req (chip_req),
    .dig_req (dig_req),
    .ana_req (ana_req),
    .rst_dig (rst_dig),
    .rst_ana (rst_ana),
    .busy (busy),
    .strap_ld (strap_ld)
  );

  rcs_regs #(.MODE_W(MODE_W)) u_regs (
    .clk (clk),
    .rst_n (rst_n),
    .rst_dig (rst_dig),
    .busy (busy),
    .strap_ld (strap_ld),
    .strap_in (strap_in),
    .reg_we (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .sw_chip (sw_chip),
    .sw_dig (sw_dig),
    .mode (mode),
    .strap_q (strap_q)
  );
endmodule

// File: rtl/rst_cal_seq_chk.sv
module rst_cal_seq_chk #(
  parameter int MODE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_dig,
  input logic              rst_ana,
  input logic              busy,
  input logic              chip_req,
  input logic              dig_req,
  input logic              ana_req,
  input logic              pg_s,
  input logic              osc_s,
  input logic              sw_chip,
  input logic              pin_s,
  input logic              filt_hit,
  input logic              strap_ld,
  input logic [MODE_W-1:0] strap_q,
  input logic [MODE_W-1:0] mode
);
  assert_fault_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!pg_s || !osc_s) |=> (rst_dig && rst_ana));

  assert_filter_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_s |=> !filt_hit);

  assert_sw_chip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sw_chip |=> (rst_dig && rst_ana));

  assert_reset_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_dig || rst_ana) |-> busy);

  assert_dig_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_req && !busy && !chip_req && !ana_req) |=> (rst_dig && !rst_ana));

  assert_ana_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ana_req && !busy && !chip_req && !dig_req) |=> (rst_ana && !rst_dig));

  assert_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_dig && !strap_ld) |=> (mode == $past(strap_q)));
endmodule

bind rst_cal_seq rst_cal_seq_chk #(.MODE_W(MODE_W)) u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .rst_dig (rst_dig),
  .rst_ana (rst_ana),
  .busy (busy),
  .chip_req (chip_req),
  .dig_req (dig_req),
  .ana_req (ana_req),
  .pg_s (pg_s),
  .osc_s (osc_s),
  .sw_chip (sw_chip),
  .pin_s (pin_s),
  .filt_hit (filt_hit),
  .strap_ld (strap_ld),
  .strap_q (strap_q),
  .mode (mode)
);

// File: tb/rst_cal_seq_test.sv
module rst_cal_seq_test;
  localparam int FILT = 25;
  localparam int RSTC = 6;
  localparam int CAL  = 40;
  localparam int MW   = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rst_pin, pwr_good, osc_stable, pwrdn_pin, speed_sel, reg_we;
  logic [MW-1:0] strap_in;
  logic [4:0]    reg_addr;
  logic [15:0]   reg_wdata, reg_rdata;
  logic          rst_dig, rst_ana;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  int n_dig, n_ana, n_busy;

  always #4 clk = ~clk;

  rst_cal_seq #(.FILT_CYCLES(FILT), .RST_CYCLES(RSTC), .CAL_CYCLES(CAL), .MODE_W(MW)) uut (
    .clk (clk), .rst_n (rst_n), .rst_pin (rst_pin), .pwr_good (pwr_good),
    .osc_stable (osc_stable), .pwrdn_pin (pwrdn_pin), .speed_sel (speed_sel),
    .strap_in (strap_in), .reg_we (reg_we), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .rst_dig (rst_dig), .rst_ana (rst_ana)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: phase 0 idle, 1 reset, 2 calibrate; need = {straps, digital, analog}.
  logic [3:0]    m_s1, m_s2;   // {osc, pg, pd, pin} after one and two clocks
  int            m_f, m_ph, m_cnt;
  logic          m_pdd, m_spdd;
  logic [2:0]    m_need;
  logic [MW-1:0] m_mode, m_strap;

  always @(posedge clk or negedge rst_n) begin : model
    logic hold, rdig, sw, dq, aq, ld;
    logic [2:0] req;
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_f = 0; m_pdd = 0; m_spdd = 0;
      m_ph = 1; m_need = 3'b111; m_cnt = RSTC - 1; m_mode = '0; m_strap = '0;
    end else begin
      hold = (m_f == FILT) || !m_s2[2] || !m_s2[3];
      rdig = (m_ph == 1) && m_need[1];
      sw   = reg_we && !rdig && reg_addr == 5'h00 && reg_wdata[15];
      dq   = reg_we && !rdig && reg_addr == 5'h17 && reg_wdata[0];
      aq   = (m_s2[1] != m_pdd) || (speed_sel != m_spdd);
      req  = ((hold || sw) ? 3'b111 : 3'b000) | {1'b0, dq, 1'b0} | {2'b00, aq};
      ld   = (m_ph == 1) && m_need[2] && m_cnt == 0 && req == 0;
      if (ld) begin m_strap = strap_in; m_mode = strap_in; end
      else if (rdig) m_mode = m_strap;
      else if (reg_we && reg_addr == 5'h00) m_mode = reg_wdata[MW-1:0];
      if (req != 0) begin
        m_need = ((m_ph == 0) ? 3'b000 : m_need) | req;
        m_ph = 1; m_cnt = RSTC - 1;
      end else if (m_ph == 1) begin
        if (m_cnt == 0) begin
          if (m_need[0]) begin m_ph = 2; m_cnt = CAL - 1; end
          else m_ph = 0;
        end else m_cnt--;
      end else if (m_ph == 2) begin
        if (m_cnt == 0) m_ph = 0; else m_cnt--;
      end
      m_f = m_s2[0] ? ((m_f == FILT) ? FILT : m_f + 1) : 0;
      m_pdd = m_s2[1]; m_spdd = speed_sel;
      m_s2 = m_s1; m_s1 = {osc_stable, pwr_good, pwrdn_pin, rst_pin};
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk(rst_dig === ((m_ph == 1) && m_need[1]), "R6 rst_dig vs model", rst_dig, (m_ph == 1) && m_need[1]);
      chk(rst_ana === ((m_ph == 1) && m_need[0]), "R7 rst_ana vs model", rst_ana, (m_ph == 1) && m_need[0]);
      chk(reg_rdata[15] === ((reg_addr == 5'h00) && m_ph != 0), "R5 busy bit vs model",
          reg_rdata[15], (reg_addr == 5'h00) && m_ph != 0);
      chk(reg_rdata[MW-1:0] === ((reg_addr == 5'h00) ? m_mode : '0), "R9 mode field vs model",
          reg_rdata[MW-1:0], (reg_addr == 5'h00) ? m_mode : 0);
      if (rst_dig) n_dig++;
      if (rst_ana) n_ana++;
      if (reg_addr == 5'h00 && reg_rdata[15]) n_busy++;
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic clr();
    n_dig = 0; n_ana = 0; n_busy = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    tick();
    reg_we = 1'b0; reg_addr = 5'h00;
  endtask

  task automatic wait_idle();
    int g = 0;
    tick();
    while (reg_rdata[15] && g < 1000) begin tick(); g++; end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rst_pin = 0; pwr_good = 0; osc_stable = 1; pwrdn_pin = 0; speed_sel = 0;
    strap_in = 2'b10; reg_we = 0; reg_addr = 5'h00; reg_wdata = '0;
    clr();
    tick(3);
    chk(rst_dig && rst_ana, "R1 both resets during rst_n", {rst_dig, rst_ana}, 3);
    rst_n = 1'b1;
    tick(40);
    chk(rst_dig && rst_ana && reg_rdata[15], "R1 held while power not good",
        {reg_rdata[15], rst_dig, rst_ana}, 7);
    clr();
    pwr_good = 1'b1;
    wait_idle();
    chk(reg_rdata[MW-1:0] == 2'b10, "R4 straps latched at power-up", reg_rdata[MW-1:0], 2);
    chk(n_busy - n_ana == CAL, "R4 calibration length", n_busy - n_ana, CAL);
    reg_addr = 5'h05;
    tick();
    chk(reg_rdata == 16'h0000, "R5 other address reads zero", reg_rdata, 0);
    reg_addr = 5'h00;

    clr();
    rst_pin = 1'b1; tick(FILT - 1); rst_pin = 1'b0; tick(10);
    chk(n_dig == 0 && n_ana == 0, "R2 short pulse ignored", n_dig + n_ana, 0);
    clr();
    rst_pin = 1'b1; tick(FILT); rst_pin = 1'b0; tick(5);
    chk(n_dig > 0 && n_ana > 0, "R2 full-length pulse resets", n_dig, 1);
    wait_idle();

    strap_in = 2'b01;
    wr(5'h00, 16'h0003);
    chk(reg_rdata[MW-1:0] == 2'b11, "R9 mode write when idle", reg_rdata[MW-1:0], 3);
    wr(5'h00, 16'h8000);
    chk(rst_dig && rst_ana, "R3 software chip reset", {rst_dig, rst_ana}, 3);
    wait_idle();
    chk(reg_rdata[MW-1:0] == 2'b01, "R4 straps relatched", reg_rdata[MW-1:0], 1);

    wr(5'h00, 16'h0002);
    clr();
    wr(5'h17, 16'h0001);
    wait_idle();
    chk(n_dig == RSTC, "R6 digital reset length", n_dig, RSTC);
    chk(n_ana == 0, "R6 analog untouched", n_ana, 0);
    chk(n_busy == RSTC, "R6 no calibration", n_busy, RSTC);
    chk(reg_rdata[MW-1:0] == 2'b01, "R6 mode restored from straps", reg_rdata[MW-1:0], 1);

    wr(5'h17, 16'h0001);
    wr(5'h00, 16'h0003);
    wait_idle();
    chk(reg_rdata[MW-1:0] == 2'b01, "R9 write during digital reset ignored", reg_rdata[MW-1:0], 1);

    clr();
    pwrdn_pin = 1'b1;
    tick(3 + RSTC + 3);
    wr(5'h00, 16'h0002);
    chk(reg_rdata[15] && reg_rdata[MW-1:0] == 2'b10, "R9 write during calibration",
        reg_rdata, 16'h8002);
    wait_idle();
    chk(n_ana == RSTC && n_dig == 0, "R7 power-down entry analog only", n_ana, RSTC);
    chk(n_busy == RSTC + CAL, "R7 recalibration length", n_busy, RSTC + CAL);
    clr();
    pwrdn_pin = 1'b0;
    tick(3);
    wait_idle();
    chk(n_ana == RSTC && n_dig == 0, "R7 power-down exit analog only", n_ana, RSTC);

    clr();
    speed_sel = 1'b1;
    wait_idle();
    chk(n_ana == RSTC && n_dig == 0, "R8 speed change analog only", n_ana, RSTC);
    chk(n_busy == RSTC + CAL, "R8 recalibration length", n_busy, RSTC + CAL);

    pwrdn_pin = 1'b1;
    tick(3 + RSTC + 4);
    wr(5'h17, 16'h0001);
    chk(rst_dig && rst_ana, "R10 merged restart", {rst_dig, rst_ana}, 3);
    wait_idle();

    osc_stable = 1'b0;
    tick(20);
    chk(rst_dig && rst_ana && reg_rdata[15], "R1 oscillator loss", {rst_dig, rst_ana}, 3);
    osc_stable = 1'b1;
    wait_idle();
    tick(2);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule